// File: doc/BRIEF.md
# Logarithmic ADSR Envelope Generator

This block produces the amplitude envelope for one voice. The envelope is held as a logarithmic attenuation: zero is full volume and each 0x40 adds about 3 dB. The voice has four stages. Attack falls exponentially towards zero. Decay, sustain and release each rise linearly. The block moves forward by at most one step per sample tick. Its outputs are the current attenuation, a stage code and a flag that shows whether the voice is sounding.

Each stage has its own 5-bit rate. Key scaling, octave and one pitch bit turn that rate into an effective rate between 0x00 and 0x3C. The effective rate sets how many ticks pass between steps and how large each step is. Both follow a four-step pattern indexed by the step count modulo 4. A link input can end the attack early when playback passes the loop start. Key-on and key-off events are sampled only on tick cycles.

Top module: `eg_adsr`

## Requirements
- R1: Out of reset the voice is inactive. The attenuation reads 0x1FFF and the stage code is 3.
- R2: When key scaling is 0xF, the effective rate is rate*2. Otherwise it is (scaling + signed octave + rate)*2 + pitch bit, clamped to the range 0x00 to 0x3C.
- R3: On a tick, key-on is accepted only if the voice is inactive or is in release. An accepted key-on sets active, stage 0 and attenuation 0x280. In any other stage, key-on changes nothing.
- R4: Each attack step subtracts (level>>N)+1 and stops at 0. N is 4 at effective rate 0x30 or below and 1 at 0x3C or above. Between those, N drops by 1 for every fourth rate, and some step phases run one lower. When the level reaches 0, the stage becomes decay (code 1).
- R5: Each decay, sustain or release step adds a constant. The constant is 1 at rate 0x30 or below and 8 at 0x3C or above. Between those it doubles for every fourth rate, with some step phases doubled again. For example, rate 0x35 gives 4,2,2,2.
- R6: Effective rates 0 and 1 never step. Rate 2 steps after 8192, 4096 and 4096 ticks. Rate 5 steps after 4096 ticks three times, then after 2048 ticks twice. Every further 4 rates halve the intervals, and rate 0x30 and above step every 2 ticks. The interval pattern restarts on each stage change.
- R7: In decay, a tick on which the level is at least DL*32 moves the stage to sustain (code 2) and takes no step.
- R8: Key-off on a tick moves an active voice that is not in release to release (code 3).
- R9: A level above 0x3BF makes the voice inactive, and the attenuation then reads 0x1FFF. While active, the attenuation never exceeds 0x3BF.
- R10: In attack, a tick with the link enable and the loop-passed input both high moves the stage to decay and leaves the level unchanged.
- R11: On cycles without a tick, the attenuation, stage and active flag do not change, whatever the event inputs do.
- R12: The stage code is 0 for attack, 1 for decay, 2 for sustain and 3 for release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample-tick enable |
| key_on | input | 1 | Key-on event |
| key_off | input | 1 | Key-off event |
| atk_rate | input | 5 | Attack rate |
| dec_rate | input | 5 | Decay rate |
| sus_rate | input | 5 | Sustain rate |
| rel_rate | input | 5 | Release rate |
| dec_lvl | input | 5 | Decay-to-sustain level (threshold DL*32) |
| krs | input | 4 | Key rate scaling; 0xF turns scaling off |
| oct | input | 4 | Signed octave |
| fns_msb | input | 1 | Pitch bit added to the effective rate |
| link_en | input | 1 | Enables an early end of the attack at loop start |
| loop_passed | input | 1 | High when playback has passed the loop start |
| atten | output | 13 | Attenuation, or 0x1FFF when inactive |
| stage | output | 2 | Stage code |
| active | output | 1 | Voice is sounding |

## Verification
The assertions assume that reset is held until the first clock edges have passed. They also assume that rate, level and scaling inputs change only between ticks, so a monotonic check compares two levels produced under the same stage rules. The bench changes those fields only between episodes, at the falling edge. It drives the event inputs, the tick and loop-passed as random pulses, all at the falling edge. A reference model in the bench takes each tick in step with the design.

// File: rtl/eg_pkg.sv
package eg_pkg;
    localparam int RATE_W     = 5;
    localparam int ERATE_W    = 6;
    localparam int LVL_W      = 11;
    localparam int OUT_W      = 13;
    localparam int TMR_W      = 14;
    localparam int BASE_LOG2  = 12;

    localparam logic [ERATE_W-1:0] ERATE_FAST = 6'h30;
    localparam logic [ERATE_W-1:0] ERATE_MAX  = 6'h3C;
    localparam logic [LVL_W-1:0]   LVL_CEIL   = 11'h3BF;
    localparam logic [LVL_W-1:0]   LVL_START  = 11'h280;
    localparam logic [OUT_W-1:0]   OUT_DEAD   = 13'h1FFF;

    typedef enum logic [1:0] {
        ST_ATK = 2'd0,
        ST_DEC = 2'd1,
        ST_SUS = 2'd2,
        ST_REL = 2'd3
    } eg_stage_e;

    typedef struct packed {
        eg_stage_e          stage;
        logic               active;
        logic [LVL_W-1:0]   level;
    } eg_state_t;

    // Phase k of the four-step pattern takes the faster step for sub-rate m.
    function automatic logic fast_phase(input logic [1:0] m, input logic [1:0] k);
        case (m)
            2'd1:    fast_phase = (k == 2'd0);
            2'd2:    fast_phase = ~k[0];
            2'd3:    fast_phase = (k != 2'd3);
            default: fast_phase = 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/eg_rate_calc.sv
module eg_rate_calc
    import eg_pkg::*;
(
    input  logic [RATE_W-1:0]  rate,
    input  logic [3:0]         krs,
    input  logic [3:0]         oct,
    input  logic               fns_msb,
    output logic [ERATE_W-1:0] erate
);
    logic signed [7:0] sum;
    logic signed [8:0] dbl;

    always_comb begin
        sum = $signed({3'b0, rate}) + $signed({4'b0, krs}) + $signed({{4{oct[3]}}, oct});
        if (krs == 4'hF)
            dbl = $signed({3'b0, rate, 1'b0});
        else
            dbl = $signed({sum, 1'b0}) + $signed({8'b0, fns_msb});
        if (dbl < 9'sd0)
            erate = '0;
        else if (dbl > 9'sd60)
            erate = ERATE_MAX;
        else
            erate = dbl[ERATE_W-1:0];
    end
endmodule

// File: rtl/eg_step_timer.sv
module eg_step_timer
    import eg_pkg::*;
#(
    parameter int CNT_W     = TMR_W,
    parameter int BASE_SHFT = BASE_LOG2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               restart,
    input  logic [ERATE_W-1:0] erate,
    output logic               step,
    output logic [1:0]         phase
);
    localparam logic [CNT_W-1:0] BASE_MAX = CNT_W'(1) << BASE_SHFT;

    logic [ERATE_W-1:0] r_eff, r_off;
    logic [1:0]         pat;
    logic [3:0]         grp;
    logic [CNT_W-1:0]   base, interval, tmr;
    logic [CNT_W:0]     tmr_nx;
    logic [2:0]         pos, pos_last;

    always_comb begin
        r_eff = (erate > ERATE_FAST) ? ERATE_FAST : erate;
        r_off = r_eff - 6'd2;
        pat   = r_off[1:0];
        grp   = r_off[5:2];
        base  = BASE_MAX >> grp;
        case (pat)
            2'd0: begin
                interval = (pos == 3'd0) ? (base << 1) : base;
                pos_last = 3'd2;
            end
            2'd1: begin
                interval = (pos == 3'd0) ? (base << 1) : base;
                pos_last = 3'd6;
            end
            2'd2: begin
                interval = base;
                pos_last = 3'd0;
            end
            default: begin
                interval = (pos >= 3'd3) ? (base >> 1) : base;
                pos_last = 3'd4;
            end
        endcase
        if (r_eff < 6'd2)
            interval = '0;
        tmr_nx = {1'b0, tmr} + 1'b1;
        step   = tick && (interval != '0) && (tmr_nx >= {1'b0, interval});
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            tmr   <= '0;
            pos   <= '0;
            phase <= '0;
        end else if (tick && interval != '0) begin
            if (step) begin
                tmr   <= '0;
                pos   <= (pos >= pos_last) ? 3'd0 : pos + 3'd1;
                phase <= phase + 2'd1;
            end else begin
                tmr   <= tmr_nx[CNT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/eg_step_size.sv
module eg_step_size
    import eg_pkg::*;
(
    input  logic [ERATE_W-1:0] erate,
    input  logic [1:0]         phase,
    output logic [2:0]         atk_shift,
    output logic [3:0]         rise
);
    logic [3:0] d;
    logic [1:0] q;
    logic       f;

    always_comb begin
        d = 4'(erate - ERATE_FAST);
        q = d[3:2];
        f = fast_phase(d[1:0], phase);
        if (erate <= ERATE_FAST) begin
            atk_shift = 3'd4;
            rise      = 4'd1;
        end else if (erate >= ERATE_MAX) begin
            atk_shift = 3'd1;
            rise      = 4'd8;
        end else begin
            atk_shift = 3'd4 - {1'b0, q} - {2'b0, f};
            rise      = 4'd1 << ({1'b0, q} + {2'b0, f});
        end
    end
endmodule

// File: rtl/eg_adsr.sv
module eg_adsr
    import eg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              key_on,
    input  logic              key_off,
    input  logic [RATE_W-1:0] atk_rate,
    input  logic [RATE_W-1:0] dec_rate,
    input  logic [RATE_W-1:0] sus_rate,
    input  logic [RATE_W-1:0] rel_rate,
    input  logic [4:0]        dec_lvl,
    input  logic [3:0]        krs,
    input  logic [3:0]        oct,
    input  logic              fns_msb,
    input  logic              link_en,
    input  logic              loop_passed,
    output logic [OUT_W-1:0]  atten,
    output logic [1:0]        stage,
    output logic              active
);
    eg_state_t          cur, nxt;
    logic               restart, step;
    logic [1:0]         phase;
    logic [RATE_W-1:0]  sel_rate;
    logic [ERATE_W-1:0] erate;
    logic [2:0]         atk_shift;
    logic [3:0]         rise;
    logic [LVL_W-1:0]   atk_dec, rise_sum, dec_thr;

    always_comb begin
        unique case (cur.stage)
            ST_ATK: sel_rate = atk_rate;
            ST_DEC: sel_rate = dec_rate;
            ST_SUS: sel_rate = sus_rate;
            ST_REL: sel_rate = rel_rate;
        endcase
    end

    eg_rate_calc u_rate (
        .rate    (sel_rate),
        .krs     (krs),
        .oct     (oct),
        .fns_msb (fns_msb),
        .erate   (erate)
    );

    eg_step_timer u_timer (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .restart (restart),
        .erate   (erate),
        .step    (step),
        .phase   (phase)
    );

    eg_step_size u_size (
        .erate     (erate),
        .phase     (phase),
        .atk_shift (atk_shift),
        .rise      (rise)
    );

    always_comb begin
        nxt      = cur;
        restart  = 1'b0;
        atk_dec  = (cur.level >> atk_shift) + 11'd1;
        rise_sum = cur.level + {7'b0, rise};
        dec_thr  = {1'b0, dec_lvl, 5'b0};
        if (tick) begin
            if (key_on && (!cur.active || cur.stage == ST_REL)) begin
                nxt.active = 1'b1;
                nxt.stage  = ST_ATK;
                nxt.level  = LVL_START;
                restart    = 1'b1;
            end else if (key_off && cur.active && cur.stage != ST_REL) begin
                nxt.stage  = ST_REL;
                restart    = 1'b1;
            end else if (cur.active) begin
                unique case (cur.stage)
                    ST_ATK: begin
                        if (link_en && loop_passed) begin
                            nxt.stage = ST_DEC;
                            restart   = 1'b1;
                        end else if (step) begin
                            if (atk_dec >= cur.level) begin
                                nxt.level = '0;
                                nxt.stage = ST_DEC;
                                restart   = 1'b1;
                            end else begin
                                nxt.level = cur.level - atk_dec;
                            end
                        end
                    end
                    ST_DEC: begin
                        if (cur.level >= dec_thr) begin
                            nxt.stage = ST_SUS;
                            restart   = 1'b1;
                        end else if (step) begin
                            nxt.level = rise_sum;
                        end
                    end
                    ST_SUS, ST_REL: begin
                        if (step)
                            nxt.level = rise_sum;
                    end
                endcase
                if (nxt.level > LVL_CEIL)
                    nxt.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.stage  <= ST_REL;
            cur.active <= 1'b0;
            cur.level  <= '1;
        end else begin
            cur <= nxt;
        end
    end

    assign atten  = cur.active ? {2'b0, cur.level} : OUT_DEAD;
    assign stage  = cur.stage;
    assign active = cur.active;
endmodule

// File: rtl/eg_adsr_chk.sv
module eg_adsr_chk (
    input logic        clk,
    input logic        rst,
    input logic        tick,
    input logic        key_on,
    input logic        key_off,
    input logic [12:0] atten,
    input logic [1:0]  stage,
    input logic        active
);
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(atten) && $stable(stage) && $stable(active))); // R11

    AST_DEAD_CODE: assert property (@(posedge clk) disable iff (rst)
        !active |-> (atten == 13'h1FFF)); // R9

    AST_LIVE_RANGE: assert property (@(posedge clk) disable iff (rst)
        active |-> (atten <= 13'h3BF)); // R9

    AST_KEYON_START: assert property (@(posedge clk) disable iff (rst)
        (tick && key_on && (!active || stage == 2'd3))
        |=> (active && stage == 2'd0 && atten == 13'h280)); // R3

    AST_ATTACK_FALLS: assert property (@(posedge clk) disable iff (rst)
        (active && stage == 2'd0) |=> (atten <= $past(atten))); // R4

    AST_LINEAR_RISES: assert property (@(posedge clk) disable iff (rst)
        (active && stage != 2'd0 && !(tick && key_on && stage == 2'd3))
        |=> (!active || atten >= $past(atten))); // R5

    AST_KEYOFF_REL: assert property (@(posedge clk) disable iff (rst)
        (tick && key_off && !key_on && active) |=> (stage == 2'd3)); // R8
endmodule

bind eg_adsr eg_adsr_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .key_on  (key_on),
    .key_off (key_off),
    .atten   (atten),
    .stage   (stage),
    .active  (active)
);

// File: tb/eg_adsr_tb.sv
`timescale 1ns/1ps
module eg_adsr_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0, key_on = 1'b0, key_off = 1'b0;
    logic [4:0]  atk_rate = '0, dec_rate = '0, sus_rate = '0, rel_rate = '0, dec_lvl = '0;
    logic [3:0]  krs = 4'hF, oct = '0;
    logic        fns_msb = 1'b0, link_en = 1'b0, loop_passed = 1'b0;
    logic [12:0] atten;
    logic [1:0]  stage;
    logic        active;

    int total = 0, bad = 0;
    int m_lvl, m_tmr, m_pos, m_ph, m_stg;
    bit m_act;

    always #2.5 clk = ~clk;

    eg_adsr u_dut (
        .clk(clk), .rst(rst), .tick(tick), .key_on(key_on), .key_off(key_off),
        .atk_rate(atk_rate), .dec_rate(dec_rate), .sus_rate(sus_rate), .rel_rate(rel_rate),
        .dec_lvl(dec_lvl), .krs(krs), .oct(oct), .fns_msb(fns_msb),
        .link_en(link_en), .loop_passed(loop_passed),
        .atten(atten), .stage(stage), .active(active)
    );

    task automatic chk(input string tag, input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int f_erate(input int r);
        int v;
        if (krs == 4'hF) v = r * 2;
        else v = (int'(krs) + int'($signed(oct)) + r) * 2 + int'(fns_msb);
        if (v < 0) v = 0;
        if (v > 60) v = 60;
        return v;
    endfunction

    function automatic int f_interval(input int r, input int pos);
        int rr, b;
        if (r < 2) return 0;
        rr = (r > 48) ? 48 : r;
        b = 4096 >> ((rr - 2) / 4);
        case ((rr - 2) % 4)
            0, 1:    return (pos == 0) ? 2 * b : b;
            2:       return b;
            default: return (pos >= 3) ? b / 2 : b;
        endcase
    endfunction

    function automatic int f_last(input int r);
        int rr = (r > 48) ? 48 : r;
        case ((rr - 2) % 4)
            0: return 2;
            1: return 6;
            2: return 0;
            default: return 4;
        endcase
    endfunction

    function automatic int f_fast(input int r, input int ph);
        int mask;
        case ((r - 48) % 4)
            1: mask = 4'b0001;
            2: mask = 4'b0101;
            3: mask = 4'b0111;
            default: mask = 0;
        endcase
        return (mask >> ph) & 1;
    endfunction

    function automatic int f_shift(input int r, input int ph);
        if (r <= 48) return 4;
        if (r >= 60) return 1;
        return 4 - (r - 48) / 4 - f_fast(r, ph);
    endfunction

    function automatic int f_add(input int r, input int ph);
        if (r <= 48) return 1;
        if (r >= 60) return 8;
        return 1 << ((r - 48) / 4 + f_fast(r, ph));
    endfunction

    task automatic model_step(input bit tk, input bit kon, input bit koff, input bit lp);
        int r, iv, nl, rsel;
        bit st, rs;
        rs = 0;
        case (m_stg)
            0: rsel = int'(atk_rate);
            1: rsel = int'(dec_rate);
            2: rsel = int'(sus_rate);
            default: rsel = int'(rel_rate);
        endcase
        r  = f_erate(rsel);
        iv = f_interval(r, m_pos);
        st = tk && iv != 0 && (m_tmr + 1 >= iv);
        if (tk) begin
            if (kon && (!m_act || m_stg == 3)) begin
                m_act = 1; m_stg = 0; m_lvl = 640; rs = 1;
            end else if (koff && m_act && m_stg != 3) begin
                m_stg = 3; rs = 1;
            end else if (m_act) begin
                case (m_stg)
                    0: if (link_en && lp) begin
                           m_stg = 1; rs = 1;
                       end else if (st) begin
                           nl = m_lvl - ((m_lvl >> f_shift(r, m_ph)) + 1);
                           if (nl <= 0) begin nl = 0; m_stg = 1; rs = 1; end
                           m_lvl = nl;
                       end
                    1: if (m_lvl >= int'(dec_lvl) * 32) begin
                           m_stg = 2; rs = 1;
                       end else if (st) m_lvl += f_add(r, m_ph);
                    default: if (st) m_lvl += f_add(r, m_ph);
                endcase
                if (m_lvl > 959) m_act = 0;
            end
        end
        if (rs) begin
            m_tmr = 0; m_pos = 0; m_ph = 0;
        end else if (tk && iv != 0) begin
            if (st) begin
                m_tmr = 0;
                m_pos = (m_pos >= f_last(r)) ? 0 : m_pos + 1;
                m_ph  = (m_ph + 1) % 4;
            end else m_tmr++;
        end
    endtask

    task automatic cmp();
        chk((m_stg == 0) ? "R4" : "R5", int'(atten), m_act ? m_lvl : 8191, "level");
        chk("R12", int'(stage), m_stg, "stage");
        chk("R9", int'(active), int'(m_act), "active");
    endtask

    task automatic cyc(input bit tk, input bit kon, input bit koff, input bit lp);
        tick = tk; key_on = kon; key_off = koff; loop_passed = lp;
        model_step(tk, kon, koff, lp);
        @(posedge clk);
        @(negedge clk);
        cmp();
    endtask

    task automatic ticks_to_change(output int n);
        int prev = int'(atten);
        n = 0;
        do begin
            cyc(1, 0, 0, 0);
            n++;
        end while (int'(atten) == prev && n < 9000);
    endtask

    task automatic silence();
        cyc(1, 0, 1, 0);
        krs = 4'hF; rel_rate = 5'd31;
        for (int i = 0; i < 400 && active; i++) cyc(1, 0, 0, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++; total++;
        $display("FAIL R1 watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n, prev;
        void'($urandom(32'd20517));
        m_act = 0; m_stg = 3; m_lvl = 0; m_tmr = 0; m_pos = 0; m_ph = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1", int'(atten), 13'h1FFF, "reset level");
        chk("R1", int'(stage), 3, "reset stage");
        chk("R1", int'(active), 0, "reset active");

        // R6: effective rate 2 steps after 8192 then 4096 ticks
        krs = 4'hF; atk_rate = 5'd1;
        cyc(1, 1, 0, 0);
        chk("R3", int'(atten), 13'h280, "key-on start level");
        ticks_to_change(n); chk("R6", n, 8192, "rate2 first interval");
        ticks_to_change(n); chk("R6", n, 4096, "rate2 second interval");
        silence();

        // R2: scaling 3, octave -8, rate 7, pitch bit 1 -> effective rate 5
        krs = 4'h3; oct = 4'h8; fns_msb = 1'b1; atk_rate = 5'd7;
        cyc(1, 1, 0, 0);
        ticks_to_change(n); chk("R2", n, 4096, "scaled rate interval");
        silence();

        // R6: negative sum clamps to rate 0, which never steps
        krs = 4'h0; oct = 4'h8; fns_msb = 1'b0; atk_rate = 5'd3;
        cyc(1, 1, 0, 0);
        repeat (10000) cyc(1, 0, 0, 0);
        chk("R6", int'(atten), 13'h280, "rate0 holds");
        silence();

        // Full envelope at top rates
        krs = 4'hF; oct = '0; atk_rate = 5'd31; dec_rate = 5'd31;
        sus_rate = 5'd31; rel_rate = 5'd31; dec_lvl = 5'd4;
        cyc(1, 1, 0, 0);
        for (int i = 0; i < 500 && stage == 2'd0; i++) cyc(1, 0, 0, 0);
        chk("R4", int'(atten), 0, "attack ends at zero");
        chk("R4", int'(stage), 1, "attack hands to decay");
        cyc(1, 1, 0, 0);
        chk("R3", int'(stage), 1, "key-on in decay ignored");
        for (int i = 0; i < 500 && stage == 2'd1; i++) cyc(1, 0, 0, 0);
        chk("R7", int'(stage), 2, "decay reaches sustain");
        chk("R7", int'(atten >= 13'h80), 1, "sustain entry level >= DL*32");
        prev = int'(atten);
        repeat (5) cyc(0, 1, 1, 1);
        chk("R11", int'(atten), prev, "no tick holds level");
        chk("R11", int'(stage), 2, "no tick holds stage");
        cyc(1, 0, 1, 0);
        chk("R8", int'(stage), 3, "key-off to release");
        for (int i = 0; i < 2000 && active; i++) cyc(1, 0, 0, 0);
        chk("R9", int'(active), 0, "release ends inactive");
        chk("R9", int'(atten), 13'h1FFF, "inactive level code");

        // R10: link ends attack at loop start
        atk_rate = 5'd1; link_en = 1'b1;
        cyc(1, 1, 0, 0);
        cyc(1, 0, 0, 1);
        chk("R10", int'(stage), 1, "link moves to decay");
        chk("R10", int'(atten), 13'h280, "link keeps level");
        link_en = 1'b0;
        silence();

        // Constrained random episodes against the model
        for (int ep = 0; ep < 200; ep++) begin
            atk_rate = 5'(16 + $urandom % 16);
            dec_rate = 5'(16 + $urandom % 16);
            sus_rate = 5'(16 + $urandom % 16);
            rel_rate = 5'(16 + $urandom % 16);
            dec_lvl  = 5'($urandom % 32);
            krs      = 4'($urandom % 16);
            oct      = 4'($urandom % 16);
            fns_msb  = 1'($urandom % 2);
            link_en  = 1'($urandom % 2);
            cyc(1, 1, 0, 0);
            for (int i = 0; i < 400; i++)
                cyc(($urandom % 8) != 0, ($urandom % 64) == 0,
                    ($urandom % 64) == 0, ($urandom % 16) == 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule